// File: doc/BRIEF.md
# Three-wire serial EEPROM command front end

This block is the slave-side serial port of a small three-wire EEPROM. Chip select, serial clock and serial data in are brought into the system clock domain through two-flop synchronizers, and edges of chip select and of the serial clock are detected there. The block waits for a start bit, shifts in a two-bit opcode and an address field, and then decodes one of seven instructions. A select input picks word organization (16-bit words) or byte organization (8-bit bytes), and this choice changes the width of the address and data fields.

Reads are served inline. The block issues one-cycle requests on a synchronous read port into the storage array and shifts the returned byte or word out on the data output. A leading zero comes first. The block keeps streaming successive locations for as long as chip select stays high, and it wraps from the top location back to zero. Every other instruction is passed to a programming controller as a single-cycle command pulse. The pulse carries an operation code, an address and data, and it fires only when chip select falls after a frame whose serial clock count is exactly right.

Top module: `mw_eeprom_frontend`

## Requirements
- R1: After reset and while chip select is low, `sdo_oe_o`, `cmd_valid_o` and `rd_req_o` are all 0.
- R2: After chip select rises, zeros sampled on rising serial clock edges are skipped. The first 1 is the start bit, and the opcode follows it.
- R3: Opcode 10 is read, 01 is write (code 1) and 11 is erase (code 2). Opcode 00 is qualified by the two top address-field bits: 11 gives enable-writes (code 3), 00 gives disable-writes (code 4), 10 gives erase-all (code 5) and 01 gives write-all (code 6). The code appears on `cmd_op_o`.
- R4: The address field is 8 bits with `org_i`=1 (the low 7 bits address one of 128 words) and 9 bits with `org_i`=0 (the low 8 bits address one of 256 bytes). The top field bit does not reach any address output.
- R5: Write and write-all take 16 data bits with `org_i`=1 and 8 with `org_i`=0, MSB first. In byte mode the data sits in the low 8 bits of `cmd_data_o` and the upper bits are zero.
- R6: A complete non-read frame produces exactly one `cmd_valid_o` cycle, a few clocks after chip select falls. Operation, address and data are valid in that cycle.
- R7: A frame with fewer or more serial clock rises than its exact length, or one aborted by chip select falling, produces no command pulse.
- R8: A read first shows a 0 on `sdo_o` after the last address bit. It then shows the addressed byte or word MSB first, one bit per rising serial clock, taken from `rd_data_i` one cycle after `rd_req_o`.
- R9: While chip select stays high, the next location follows at once with no leading zero. The address wraps from 127 (word) or 255 (byte) to 0.
- R10: `sdo_oe_o` is 1 only while chip select is high and the block is either waiting for a start bit or streaming read data. It is 0 while a command is being shifted in.
- R11: While waiting for a start bit, `sdo_o` shows ready status (the inverse of `busy_i`). While `busy_i` is 1, no start bit is accepted, so a frame sent then is ignored.
- R12: A read never produces a command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Serial chip select, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| org_i | input | 1 | 1: word organization, 0: byte organization |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data out pad |
| rd_req_o | output | 1 | Storage read request, one cycle |
| rd_addr_o | output | WADDR_W+1 | Storage read address (word or byte index) |
| rd_data_i | input | DATA_W | Storage read data, valid one cycle after request |
| busy_i | input | 1 | Programming controller busy |
| cmd_valid_o | output | 1 | Command pulse to the programming controller |
| cmd_op_o | output | 3 | Command code |
| cmd_addr_o | output | WADDR_W+1 | Command address |
| cmd_data_o | output | DATA_W | Command data |

## Verification
The bench builds the block with its default parameters: a 7-bit word index and 16-bit data, which gives 128 words or 256 bytes. At this size every location in both organizations is reachable. One streaming read per organization walks the whole array and crosses the wrap point. Erase and write commands are swept across the address range with a fixed stride in both modes. All four overloaded opcode-00 commands, short and long frames, and frames sent while busy are also driven.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_WR_EN     = 3'd3,
    CMD_WR_DIS    = 3'd4,
    CMD_ERASE_ALL = 3'd5,
    CMD_WRITE_ALL = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_OP, ST_ADDR, ST_DATA, ST_DONE, ST_READ, ST_OVER
  } rx_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[i]};
    end
    assign sync_o[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/mw_rx_decoder.sv
module mw_rx_decoder
  import mw_pkg::*;
#(
  parameter int WADDR_W = 7,
  parameter int DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_lvl_i,
  input  logic               cs_fall_i,
  input  logic               sck_rise_i,
  input  logic               sdi_i,
  input  logic               org_i,
  input  logic               busy_i,
  output rx_state_e          state_o,
  output logic               read_go_o,
  output logic [WADDR_W:0]   read_addr_o,
  output logic               cmd_valid_o,
  output cmd_e               cmd_op_o,
  output logic [WADDR_W:0]   cmd_addr_o,
  output logic [DATA_W-1:0]  cmd_data_o
);
  localparam int FIELD_W = WADDR_W + 2;
  localparam int LMAX    = (DATA_W > FIELD_W) ? DATA_W : FIELD_W;
  localparam int CNT_W   = $clog2(LMAX);

  rx_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [1:0]          op_q;
  logic [FIELD_W-1:0]  field_q;
  logic [DATA_W-1:0]   data_q;
  cmd_e                cmd_q;
  logic                valid_q;

  logic [CNT_W-1:0]    a_last, d_last;
  logic [FIELD_W-1:0]  field_nx;
  logic [1:0]          ext;
  cmd_e                cmd_nx;

  assign a_last   = org_i ? CNT_W'(FIELD_W - 2) : CNT_W'(FIELD_W - 1);
  assign d_last   = org_i ? CNT_W'(DATA_W - 1)  : CNT_W'(DATA_W / 2 - 1);
  assign field_nx = {field_q[FIELD_W-2:0], sdi_i};
  // qualifier bits are the two top bits of the active field length
  assign ext      = org_i ? field_nx[FIELD_W-2 -: 2] : field_nx[FIELD_W-1 -: 2];

  always_comb begin
    case (op_q)
      2'b01:   cmd_nx = CMD_WRITE;
      2'b11:   cmd_nx = CMD_ERASE;
      2'b00: begin
        case (ext)
          2'b11:   cmd_nx = CMD_WR_EN;
          2'b00:   cmd_nx = CMD_WR_DIS;
          2'b10:   cmd_nx = CMD_ERASE_ALL;
          default: cmd_nx = CMD_WRITE_ALL;
        endcase
      end
      default: cmd_nx = CMD_NONE;
    endcase
  end

  assign read_go_o   = sck_rise_i && cs_lvl_i && (state_q == ST_ADDR) &&
                       (cnt_q == a_last) && (op_q == 2'b10);
  assign read_addr_o = org_i ? {1'b0, field_nx[WADDR_W-1:0]} : field_nx[WADDR_W:0];
  assign cmd_addr_o  = org_i ? {1'b0, field_q[WADDR_W-1:0]}  : field_q[WADDR_W:0];
  assign cmd_data_o  = data_q;
  assign cmd_op_o    = cmd_q;
  assign cmd_valid_o = valid_q;
  assign state_o     = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      field_q <= '0;
      data_q  <= '0;
      cmd_q   <= CMD_NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cs_fall_i && (state_q == ST_DONE);
      if (!cs_lvl_i) begin
        state_q <= ST_IDLE;
      end else if (state_q == ST_IDLE) begin
        state_q <= ST_START;
      end else if (sck_rise_i) begin
        case (state_q)
          ST_START: if (sdi_i && !busy_i) begin
            state_q <= ST_OP;
            cnt_q   <= '0;
            field_q <= '0;
            data_q  <= '0;
          end
          ST_OP: begin
            op_q <= {op_q[0], sdi_i};
            if (cnt_q == CNT_W'(1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: begin
            field_q <= field_nx;
            if (cnt_q == a_last) begin
              cnt_q <= '0;
              if (op_q == 2'b10) begin
                state_q <= ST_READ;
              end else begin
                cmd_q   <= cmd_nx;
                state_q <= (cmd_nx == CMD_WRITE || cmd_nx == CMD_WRITE_ALL) ? ST_DATA : ST_DONE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            data_q <= {data_q[DATA_W-2:0], sdi_i};
            if (cnt_q == d_last) state_q <= ST_DONE;
            else                 cnt_q   <= cnt_q + 1'b1;
          end
          ST_DONE: state_q <= ST_OVER;  // extra clock: frame rejected
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_read_tx.sv
module mw_read_tx #(
  parameter int WADDR_W = 7,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              org_i,
  input  logic              go_i,
  input  logic [WADDR_W:0]  go_addr_i,
  input  logic              active_i,
  input  logic              sck_rise_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [WADDR_W:0]  rd_addr_o,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;

  logic [WADDR_W:0]  addr_q, addr_nx;
  logic [DATA_W-1:0] word_q, shreg_q, aligned;
  logic [IDX_W-1:0]  idx_q, w_last;
  logic              bit_q, req_q, ld_q;

  assign w_last  = org_i ? IDX_W'(DATA_W - 1) : IDX_W'(HALF - 1);
  assign aligned = org_i ? rd_data_i : {rd_data_i[HALF-1:0], {HALF{1'b0}}};
  assign addr_nx = org_i ? {1'b0, addr_q[WADDR_W-1:0] + 1'b1} : addr_q + 1'b1;

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
  assign bit_o     = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      word_q  <= '0;
      shreg_q <= '0;
      idx_q   <= '0;
      bit_q   <= 1'b0;
      req_q   <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      ld_q  <= req_q;
      if (ld_q) word_q <= aligned;
      if (go_i) begin
        addr_q <= go_addr_i;
        req_q  <= 1'b1;
        bit_q  <= 1'b0;       // leading zero
        idx_q  <= '0;
      end else if (active_i && sck_rise_i) begin
        if (idx_q == '0) begin
          // first bit of a location; prefetch the next one
          bit_q   <= word_q[DATA_W-1];
          shreg_q <= {word_q[DATA_W-2:0], 1'b0};
          idx_q   <= w_last;
          addr_q  <= addr_nx;
          req_q   <= 1'b1;
        end else begin
          bit_q   <= shreg_q[DATA_W-1];
          shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
          idx_q   <= idx_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_frontend.sv
module mw_eeprom_frontend
  import mw_pkg::*;
#(
  parameter int WADDR_W     = 7,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              org_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              rd_req_o,
  output logic [WADDR_W:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              busy_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [WADDR_W:0]  cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic [2:0] sync_lvl;
  logic       cs_lvl, sck_lvl, sdi_lvl;
  logic       cs_d, sck_d, cs_fall, sck_rise;

  mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdi_i, sck_i, cs_i}),
    .sync_o  (sync_lvl)
  );

  assign cs_lvl  = sync_lvl[0];
  assign sck_lvl = sync_lvl[1];
  assign sdi_lvl = sync_lvl[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_lvl;
      sck_d <= sck_lvl;
    end
  end

  assign cs_fall  = cs_d & ~cs_lvl;
  assign sck_rise = sck_lvl & ~sck_d;

  rx_state_e        rx_state;
  logic             read_go;
  logic [WADDR_W:0] read_addr;
  cmd_e             cmd_op;
  logic             tx_bit;

  mw_rx_decoder #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_lvl_i    (cs_lvl),
    .cs_fall_i   (cs_fall),
    .sck_rise_i  (sck_rise),
    .sdi_i       (sdi_lvl),
    .org_i       (org_i),
    .busy_i      (busy_i),
    .state_o     (rx_state),
    .read_go_o   (read_go),
    .read_addr_o (read_addr),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o)
  );

  mw_read_tx #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .org_i      (org_i),
    .go_i       (read_go),
    .go_addr_i  (read_addr),
    .active_i   (rx_state == ST_READ),
    .sck_rise_i (sck_rise),
    .rd_data_i  (rd_data_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .bit_o      (tx_bit)
  );

  assign cmd_op_o = cmd_op;
  assign sdo_oe_o = cs_lvl & ((rx_state == ST_START) | (rx_state == ST_READ));
  assign sdo_o    = (rx_state == ST_READ) ? tx_bit : ~busy_i;
endmodule

// File: rtl/mw_frontend_checker.sv
module mw_frontend_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       sdo_oe_o,
  input logic       rd_req_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_op_o
);
  a_r10_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> $past(cs_i, SYNC_STAGES));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  a_r6_pulse_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !sdo_oe_o);

  a_r3_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_op_o != 3'd0 && cmd_op_o <= 3'd6));

  a_r8_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  a_r9_req_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> sdo_oe_o);

  a_r12_no_cmd_with_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && cmd_valid_o));
endmodule

bind mw_eeprom_frontend mw_frontend_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .sdo_oe_o    (sdo_oe_o),
  .rd_req_o    (rd_req_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o)
);

// File: tb/tb_mw_eeprom_frontend.sv
module tb_mw_eeprom_frontend;
  localparam int WA = 7;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, cs, sck, sdi, org, busy;
  logic sdo_o, sdo_oe_o, rd_req_o, cmd_valid_o;
  logic [WA:0] rd_addr_o, cmd_addr_o;
  logic [DW-1:0] rd_data, cmd_data_o;
  logic [2:0] cmd_op_o;

  mw_eeprom_frontend dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sck_i(sck), .sdi_i(sdi), .org_i(org),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data), .busy_i(busy), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
  );

  int checks = 0, fails = 0, pulses = 0;
  logic [2:0] cap_op;
  logic [WA:0] cap_addr;
  logic [DW-1:0] cap_data;

  function automatic logic [15:0] mf(input logic [WA:0] a);
    return (16'(a) * 16'h9E37) ^ 16'hA5C3;
  endfunction

  // storage model: synchronous read
  always @(posedge clk) if (rd_req_o) rd_data <= org ? mf(rd_addr_o) : {8'h00, mf(rd_addr_o) & 16'h00FF};

  always @(negedge clk) if (cmd_valid_o) begin
    pulses++;
    cap_op = cmd_op_o; cap_addr = cmd_addr_o; cap_data = cmd_data_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b, output logic q);
    sdi = b;
    repeat (4) @(negedge clk);
    q = sdo_o;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic cs_on();
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    cs = 1'b0; sdi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic int alen();
    return org ? 8 : 9;
  endfunction

  // frame: lead zeros, start, op, field, data; extra adds zeros or drops bits
  task automatic frame(input logic [1:0] op, input logic [8:0] field, input logic [15:0] data,
                       input int extra, input int lead);
    logic [63:0] v;
    logic q;
    int n, dl;
    logic [1:0] ext;
    ext = org ? field[7:6] : field[8:7];
    dl = (op == 2'b01 || (op == 2'b00 && ext == 2'b01)) ? (org ? 16 : 8) : 0;
    v = 64'd1;
    v = (v << 2) | 64'(op);
    v = (v << alen()) | (64'(field) & ((64'd1 << alen()) - 1));
    v = (v << dl) | (64'(data) & ((64'd1 << dl) - 1));
    n = 3 + alen() + dl;
    cs_on();
    for (int i = 0; i < lead; i++) tick(1'b0, q);
    for (int i = n - 1; i >= 0; i--) if (n - 1 - i < n + extra) tick(v[i], q);
    for (int i = 0; i < extra; i++) tick(1'b0, q);
    cs_off();
  endtask

  task automatic expect_cmd(input int base, input int op, input int addr, input int data,
                            input bit chk_addr, input string req);
    chk(pulses - base == 1, {req, " pulse count"}, pulses - base, 1);
    chk(cap_op == 3'(op), {req, " op"}, cap_op, op);
    if (chk_addr) chk(cap_addr == (WA + 1)'(addr), {req, " addr"}, cap_addr, addr);
    chk(cap_data == 16'(data), {req, " data"}, cap_data, data);
  endtask

  task automatic do_read(input int start, input int nloc, input bit top_bit);
    logic q;
    int depth, wl, a, base;
    logic [15:0] w, e;
    logic [8:0] fld;
    depth = org ? 128 : 256;
    wl = org ? 16 : 8;
    base = pulses;
    fld = 9'(start);
    if (top_bit) fld[alen() - 1] = 1'b1;
    cs_on();
    tick(1'b1, q); tick(1'b1, q); tick(1'b0, q);
    for (int i = alen() - 1; i >= 0; i--) tick(fld[i], q);
    tick(1'b0, q);
    chk(q == 1'b0, "R8 leading zero", q, 0);
    a = start;
    for (int k = 0; k < nloc; k++) begin
      w = '0;
      for (int b = 0; b < wl; b++) begin
        tick(1'b0, q);
        w = {w[14:0], q};
      end
      e = org ? mf((WA + 1)'(a)) : (mf((WA + 1)'(a)) & 16'h00FF);
      chk(w == e, k == 0 ? "R8 first location" : "R9 streamed location", w, e);
      a = (a + 1) % depth;
    end
    cs_off();
    chk(pulses == base, "R12 no pulse on read", pulses - base, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base, depth;
    logic q;
    logic [15:0] d;
    rst_ni = 1'b0; cs = 1'b0; sck = 1'b0; sdi = 1'b0; org = 1'b1; busy = 1'b0; rd_data = '0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sdo_oe_o && !cmd_valid_o && !rd_req_o, "R1 reset quiet",
        {sdo_oe_o, cmd_valid_o, rd_req_o}, 0);

    // R10/R11 status while waiting for start
    cs_on();
    chk(sdo_oe_o == 1'b1, "R10 oe waiting for start", sdo_oe_o, 1);
    chk(sdo_o == 1'b1, "R11 ready shown", sdo_o, 1);
    busy = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo_o == 1'b0, "R11 busy shown", sdo_o, 0);
    busy = 1'b0;
    tick(1'b1, q); tick(1'b0, q);
    repeat (4) @(negedge clk);
    chk(sdo_oe_o == 1'b0, "R10 oe off while shifting command", sdo_oe_o, 0);
    cs_off();
    chk(sdo_oe_o == 1'b0, "R1 oe off with cs low", sdo_oe_o, 0);
    chk(pulses == 0, "R7 aborted frame", pulses, 0);

    for (int o = 1; o >= 0; o--) begin
      org = 1'(o);
      depth = org ? 128 : 256;
      for (int a = 0; a < depth + 11; a += 11) begin
        int ad;
        logic [8:0] f;
        ad = (a >= depth) ? depth - 1 : a;
        f = 9'(ad);
        if (ad % 2 == 1) f[alen() - 1] = 1'b1;  // top field bit ignored
        base = pulses;
        frame(2'b11, f, 16'h0, 0, 0);
        expect_cmd(base, 2, ad, 0, 1'b1, "R3 R4 erase");
        d = mf((WA + 1)'(ad)) ^ 16'h5A5A;
        base = pulses;
        frame(2'b01, f, d, 0, 0);
        expect_cmd(base, 1, ad, org ? d : (d & 16'h00FF), 1'b1, "R5 write");
      end
      for (int e = 0; e < 4; e++) begin
        logic [8:0] f;
        int exp_op;
        f = (9'(e) << (alen() - 2)) | 9'h015;
        exp_op = (e == 3) ? 3 : (e == 0) ? 4 : (e == 2) ? 5 : 6;
        base = pulses;
        frame(2'b00, f, 16'hC3A5, 0, 0);
        expect_cmd(base, exp_op, 0, (e == 1) ? (org ? 16'hC3A5 : 16'h00A5) : 0, 1'b0,
                   "R3 opcode 00 qualifier");
      end
      base = pulses;
      frame(2'b11, 9'h05, 16'h0, 0, 3);
      expect_cmd(base, 2, 5, 0, 1'b1, "R2 leading zeros");
      base = pulses;
      frame(2'b01, 9'h12, 16'hBEEF, -1, 0);
      chk(pulses == base, "R7 short write", pulses - base, 0);
      base = pulses;
      frame(2'b01, 9'h12, 16'hBEEF, 1, 0);
      chk(pulses == base, "R7 long write", pulses - base, 0);
      base = pulses;
      frame(2'b11, 9'h12, 16'h0, 2, 0);
      chk(pulses == base, "R7 long erase", pulses - base, 0);
      busy = 1'b1;
      base = pulses;
      frame(2'b01, 9'h21, 16'h1234, 0, 0);
      chk(pulses == base, "R11 frame ignored while busy", pulses - base, 0);
      busy = 1'b0;
      do_read(depth - 2, 5, 1'b1);
      do_read(0, depth + 1, 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule